// File: doc/BRIEF.md
# Distributed Arithmetic Inner-Product Engine

This block computes the inner product of K unsigned input samples with K fixed unsigned coefficients and uses no multiplier. A small table, filled at elaboration from the coefficient parameter, holds the sum of every subset of the coefficients. The engine walks the sample bits from most significant to least. At each step it takes one bit from every sample, uses those K bits as the table address, doubles the running sum and adds the table word. After N steps the sum equals the full inner product.

A client places all K samples on one packed bus and pulses `start`. The engine latches the samples, reports `busy` while it works, and raises `done` for one cycle when `result` holds the finished value. The result then stays unchanged until the next accepted start. A start that arrives while the engine is busy has no effect.

Top module: `da_inner_product`

## Requirements
- R1: While reset is held and after its release, `busy` and `done` are low and `result` is zero until the first accepted start.
- R2: `result` equals the exact unsigned sum over k of COEFS[k] times sample k, in CW+N+clog2(K) bits with no overflow. This holds even when every sample and every coefficient is at its maximum.
- R3: The table entry for an address with no bits set is zero, so all-zero samples give a result of zero. The entry for the address with only bit k set equals coefficient k, so a single nonzero sample of 1 gives that sample's coefficient.
- R4: A start is accepted on a rising clock edge when `busy` is low. `done` is high for exactly one cycle, beginning N clock edges after the accepting edge.
- R5: `busy` goes high after the accepting edge and stays high through the `done` cycle. It drops in the cycle after `done`.
- R6: A start raised while `busy` is high is ignored: the running result and the timing of `done` are unchanged.
- R7: While the engine is idle and no start is raised, `result` holds its last value.
- R8: Sample k occupies bits [k*N +: N] of `samples`. The bus is read only on the accepting edge, and changes to it during a run have no effect.
- R9: A start raised in the first idle cycle after `done` is accepted, so runs can follow one another back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a computation |
| samples | input | K*N | Packed input samples, sample k at bits [k*N +: N] |
| busy | output | 1 | Computation in progress, including the done cycle |
| done | output | 1 | One-cycle pulse: result is final |
| result | output | CW+N+clog2(K) | Inner product |

## Verification
The bench drives all-maximum samples to catch a sum that is too narrow and wraps. It drives single-hot samples of value 1 to catch a table with misplaced or misordered entries, and all-zero samples to catch a nonzero base entry. It also raises start in the middle of a run with different samples on the bus, which catches a controller that restarts or reloads and so shifts `done` or changes the sum. Runs placed back to back check that a controller leaving the done state late does not drop the next request. Runs placed back to back also show that an accumulator which is not cleared on load carries the previous sum into the next result.

// File: rtl/da_ip_pkg.sv
package da_ip_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // latch samples, clear accumulator
    logic step;   // consume one bit-slice
  } daStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } daState_t;
endpackage

// File: rtl/da_ip_table.sv
module da_ip_table #(
  parameter int K  = 4,
  parameter int CW = 8,
  parameter logic [K*CW-1:0] COEFS = '0,
  localparam int TW = CW + $clog2(K)
) (
  input  logic [K-1:0]  addr,
  output logic [TW-1:0] word
);
  localparam int DEPTH = 1 << K;

  // Subset sum of the coefficients selected by the address bits
  function automatic logic [TW-1:0] subsetSum(input int a);
    logic [TW-1:0] s;
    s = '0;
    for (int k = 0; k < K; k++)
      if (((a >> k) & 1) == 1) s = s + TW'(COEFS[k*CW +: CW]);
    return s;
  endfunction

  logic [TW-1:0] entries [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign entries[g] = subsetSum(g);
  end

  assign word = entries[addr];
endmodule

// File: rtl/da_ip_datapath.sv
module da_ip_datapath
  import da_ip_pkg::*;
#(
  parameter int K  = 4,
  parameter int N  = 8,
  parameter int CW = 8,
  parameter logic [K*CW-1:0] COEFS = '0,
  localparam int TW = CW + $clog2(K),
  localparam int AW = CW + N + $clog2(K)
) (
  input  logic          clk,
  input  logic          rstN,
  input  daStrobe_t     strobe,
  input  logic [K*N-1:0] samples,
  output logic [AW-1:0] acc
);
  logic [N-1:0]  shiftReg [K];
  logic [K-1:0]  slice;
  logic [TW-1:0] tableWord;

  // Bit-slice: current MSB of every sample
  for (genvar k = 0; k < K; k++) begin : g_slice
    assign slice[k] = shiftReg[k][N-1];
  end

  da_ip_table #(.K(K), .CW(CW), .COEFS(COEFS)) u_table (
    .addr(slice),
    .word(tableWord)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < K; k++) shiftReg[k] <= '0;
      acc <= '0;
    end else if (strobe.load) begin
      for (int k = 0; k < K; k++) shiftReg[k] <= samples[k*N +: N];
      acc <= '0;
    end else if (strobe.step) begin
      for (int k = 0; k < K; k++) shiftReg[k] <= shiftReg[k] << 1;
      acc <= (acc << 1) + AW'(tableWord);
    end
  end
endmodule

// File: rtl/da_ip_ctrl.sv
module da_ip_ctrl
  import da_ip_pkg::*;
#(
  parameter int N = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  output daStrobe_t strobe,
  output logic      busy,
  output logic      done
);
  localparam int CNTW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CNTW-1:0] LAST = CNTW'(N - 1);

  daState_t state;
  logic [CNTW-1:0] bitCnt;

  always_comb begin
    strobe.load = (state == ST_IDLE) && start;
    strobe.step = (state == ST_RUN);
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state  <= ST_RUN;
          bitCnt <= '0;
        end
        ST_RUN: begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == LAST) state <= ST_FIN;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/da_inner_product.sv
module da_inner_product
  import da_ip_pkg::*;
#(
  parameter int K  = 4,
  parameter int N  = 8,
  parameter int CW = 8,
  parameter logic [K*CW-1:0] COEFS = {8'd200, 8'd90, 8'd17, 8'd255},
  localparam int AW = CW + N + $clog2(K)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic [K*N-1:0] samples,
  output logic           busy,
  output logic           done,
  output logic [AW-1:0]  result
);
  daStrobe_t strobe;

  da_ip_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .strobe(strobe), .busy(busy), .done(done)
  );

  da_ip_datapath #(.K(K), .N(N), .CW(CW), .COEFS(COEFS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .samples(samples), .acc(result)
  );
endmodule

// File: rtl/da_inner_product_chk.sv
module da_inner_product_chk #(
  parameter int N  = 8,
  parameter int AW = 18
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] result
);
  localparam int CYW = $clog2(N + 2);
  logic [CYW-1:0] cyc;

  // Cycles since the accepting edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cyc <= '0;
    else if (start && !busy) cyc <= '0;
    else if (busy && cyc != CYW'(N + 1)) cyc <= cyc + 1'b1;
  end

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r4_done_timing: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (cyc == CYW'(N)));
  a_r5_done_inside_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);
  a_r5_busy_ends_after_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(done));
  a_r6_busy_from_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));
  a_r7_result_held: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(result));
endmodule

bind da_inner_product da_inner_product_chk #(.N(N), .AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .start(start),
  .busy(busy), .done(done), .result(result)
);

// File: tb/da_inner_product_tb.sv
module da_inner_product_tb;
  localparam int CLK_PERIOD = 10;
  localparam int K  = 4;
  localparam int N  = 8;
  localparam int CW = 8;
  localparam int AW = CW + N + $clog2(K);
  localparam logic [K*CW-1:0] COEFS = {8'd200, 8'd90, 8'd17, 8'd255};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [K*N-1:0] samples = '0;
  logic busy, done;
  logic [AW-1:0] result;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  da_inner_product #(.K(K), .N(N), .CW(CW), .COEFS(COEFS)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .samples(samples),
    .busy(busy), .done(done), .result(result)
  );

  function automatic longint expectSum(input logic [K*N-1:0] s);
    longint total = 0;
    for (int k = 0; k < K; k++)
      total += longint'(COEFS[k*CW +: CW]) * longint'(s[k*N +: N]);
    return total;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Caller stands at a negedge; returns at the first idle negedge after done.
  task automatic runOne(input logic [K*N-1:0] s, input bit poke, input string req);
    longint exp = expectSum(s);
    samples = s;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R5 busy after accept", longint'(busy), 1);
    for (int i = 1; i < N; i++) begin
      @(negedge clk);
      check(done == 1'b0, "R4 no early done", longint'(done), 0);
      if (poke && i == 1) begin
        start = 1'b1;
        samples = ~s;
      end else if (poke && i == 2) begin
        start = 1'b0;
      end
    end
    @(negedge clk);
    check(done == 1'b1, "R4 done after N edges", longint'(done), 1);
    check(busy == 1'b1, "R5 busy during done", longint'(busy), 1);
    check(longint'(result) == exp, req, longint'(result), exp);
    @(negedge clk);
    check(done == 1'b0, "R4 done one cycle", longint'(done), 0);
    check(busy == 1'b0, "R5 idle after done", longint'(busy), 0);
    check(longint'(result) == exp, "R7 result held", longint'(result), exp);
  endtask

  initial begin
    logic [K*N-1:0] s;
    void'($urandom(32'd20240611));
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && result == '0, "R1 reset state", longint'(result), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && result == '0, "R1 after release", longint'(result), 0);

    // R3 zero slice
    runOne('0, 1'b0, "R3 zero inputs");
    // R3 single-hot samples of value 1 give each coefficient
    for (int k = 0; k < K; k++) begin
      s = '0;
      s[k*N] = 1'b1;
      runOne(s, 1'b0, "R3 single coefficient");
    end
    // R2 full-scale, no overflow
    runOne('1, 1'b0, "R2 all max");
    // R8 lane placement: distinct values per lane
    runOne({8'd4, 8'd3, 8'd2, 8'd1}, 1'b0, "R8 lane order");
    // R6 and R8: start and new samples mid-run are ignored
    runOne({8'd77, 8'd5, 8'd250, 8'd128}, 1'b1, "R6 start ignored while busy");

    // R7 hold across idle cycles without start
    repeat (3) @(negedge clk);
    check(longint'(result) == expectSum({8'd77, 8'd5, 8'd250, 8'd128}), "R7 idle hold",
          longint'(result), expectSum({8'd77, 8'd5, 8'd250, 8'd128}));

    // R9 back to back random runs, some with mid-run pokes (R2)
    for (int t = 0; t < 40; t++) begin
      for (int k = 0; k < K; k++) s[k*N +: N] = N'($urandom);
      runOne(s, bit'(t % 3 == 0), "R2 R9 random back to back");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule